// File: doc/BRIEF.md
# Configuration Readback Stream Serializer

This block sends the contents of a small configuration store out on one serial line, together with a snapshot of live state bits. A low-to-high change on the trigger input starts a readback. A read-in-progress flag rises on the next edge of the readback clock. On each later edge one bit of a fixed-format stream appears on the data output. When the run is finished, the flag drops and the line returns to its idle high level.

The stream has three parts. It opens with five high dummy bits. Then come the stored frames, and each frame has this layout: a low start bit, DATA_BITS payload bits sent least significant bit first, and four high check positions. The stream closes with one more low start bit and an 11-bit CRC signature. Some payload positions are always sent high: the first two payload bits of frame 0, and the last seven bits of the final frame. A window of capture positions in one frame can carry either the stored bits or the inverted state bits that were sampled at the trigger edge. The capture input decides which, and its value is taken at the trigger edge.

The store is a parameterized register array. It has a simple write port that loads one frame word per cycle, and a synchronous read port that only the serializer uses.

Top module: `cfg_readback_serializer`

## Requirements
- R1: A synchronous active-high reset, applied while idle or during a readback, leaves `rd_busy` low and `rd_data` high on the following cycle.
- R2: A readback starts only on a rising edge of `rd_trig` as seen by `clk`. `rd_busy` goes high on that same clock edge, and the data output is still high during the first busy cycle. Holding `rd_trig` high does not start another readback.
- R3: The stream opens with five dummy bits of value 1. Every frame opens with a start bit of value 0.
- R4: Data position j of frame f (j = 0 first) carries bit j of stored word f, uninverted. Words are written through `wr_en`/`wr_addr`/`wr_word`.
- R5: Data positions 0 and 1 of frame 0 are always sent as 1.
- R6: The last four bit positions of every frame are check positions, and each is sent as 1.
- R7: The last seven bit positions of the final frame (NUM_FRAMES-1) are sent as 1.
- R8: After the final frame the block sends one start bit of value 0, then an 11-bit CRC, most significant bit first. The CRC uses polynomial 0x385 (x^11+x^9+x^8+x^7+x^2+1) with initial value 0. It is shifted over every frame bit as sent, including start, data and check bits: fb = crc[10] xor bit, crc = (crc << 1) xor (fb ? 0x385 : 0). `rd_busy` falls, and `rd_data` returns to 1, on the clock edge after the last CRC bit.
- R9: If `cap_en` is 1 at the trigger edge, data positions CAP_LSB to CAP_LSB+NUM_CAP-1 of frame CAP_FRAME carry the inverse of `cap_state` as sampled at that edge. Bit k of `cap_state` goes to position CAP_LSB+k. Changes to `cap_state` after the trigger have no effect.
- R10: If `cap_en` is 0 at the trigger edge, the capture positions carry the stored word bits.
- R11: A rising edge on `rd_trig` while `rd_busy` is high is ignored. The current stream is unchanged, and no readback follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_trig | input | 1 | Trigger; a rising edge starts a readback |
| cap_en | input | 1 | Selects capture of live state, sampled at the trigger |
| cap_state | input | NUM_CAP | Live state bits to snapshot |
| wr_en | input | 1 | Store write enable |
| wr_addr | input | AW | Store word (frame) address |
| wr_word | input | DATA_BITS | Store write data |
| rd_busy | output | 1 | Read in progress |
| rd_data | output | 1 | Serial readback data, idles high |

## Verification
The store is filled with several word patterns: all zeros, all ones, alternating bits, a distinct arithmetic word per frame, and random words. All-zero contents show whether each forced-high position, each check position and each dummy bit is really forced high. All-one contents show whether the low start bits and the trailing start bit are really driven low. Distinct per-frame words catch wrong frame ordering, a wrong bit order and an off-by-one in the read prefetch. Capture runs use enabled and disabled modes with different state values, and the state is flipped just after the trigger. This separates inverted capture from plain stored bits and confirms that the state is sampled at the edge. Other runs pulse the trigger in mid-stream, hold it high, or apply reset partway through, to check the start and abort behaviour.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int CRC_W      = 11;
  localparam logic [CRC_W-1:0] CRC_POLY = 11'h385;
  localparam int DUMMY_BITS = 5;
  localparam int CHECK_BITS = 4;
  localparam int HEAD_FORCE = 2;
  localparam int TAIL_FORCE = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DUMMY,
    PH_FRAME,
    PH_TAIL,
    PH_CRC,
    PH_DONE
  } rb_phase_e;

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rb_crc11.sv
module rb_crc11
  import rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc_next(crc, din);
  end
endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import rb_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_LEN  = 17,
  parameter int CNT_W      = 5,
  parameter int FW         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output rb_phase_e        phase,
  output logic [CNT_W-1:0] cnt,
  output logic [FW-1:0]    frame_idx,
  output logic             busy
);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CRC_LAST   = CNT_W'(CRC_W - 1);
  localparam logic [FW-1:0]    LAST_FRAME = FW'(NUM_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      frame_idx <= '0;
      busy      <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_DUMMY;
          cnt       <= '0;
          frame_idx <= '0;
          busy      <= 1'b1;
        end
        PH_DUMMY: begin
          if (cnt == DUMMY_LAST) begin
            phase <= PH_FRAME;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FRAME: begin
          if (cnt == FRAME_LAST) begin
            cnt <= '0;
            if (frame_idx == LAST_FRAME) phase <= PH_TAIL;
            else frame_idx <= frame_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TAIL: begin
          phase <= PH_CRC;
          cnt   <= '0;
        end
        PH_CRC: begin
          if (cnt == CRC_LAST) phase <= PH_DONE;
          else cnt <= cnt + 1'b1;
        end
        PH_DONE: begin
          phase <= PH_IDLE;
          busy  <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_readback_serializer.sv
module cfg_readback_serializer
  import rb_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int DATA_BITS  = 12,
  parameter int NUM_CAP    = 4,
  parameter int CAP_FRAME  = 1,
  parameter int CAP_LSB    = 4,
  localparam int AW        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_trig,
  input  logic                 cap_en,
  input  logic [NUM_CAP-1:0]   cap_state,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DATA_BITS-1:0] wr_word,
  output logic                 rd_busy,
  output logic                 rd_data
);
  localparam int FRAME_LEN = 1 + DATA_BITS + CHECK_BITS;
  localparam int CNT_MAX   = (FRAME_LEN > CRC_W) ? FRAME_LEN : CRC_W;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int DIW       = $clog2(DATA_BITS);
  localparam int CIW       = (NUM_CAP > 1) ? $clog2(NUM_CAP) : 1;
  localparam int CRIW      = $clog2(CRC_W);

  localparam logic [CNT_W-1:0] C_DATA_END = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] C_HEAD_END = CNT_W'(HEAD_FORCE);
  localparam logic [CNT_W-1:0] C_TAIL_BEG = CNT_W'(FRAME_LEN - TAIL_FORCE);
  localparam logic [CNT_W-1:0] C_CAP_BEG  = CNT_W'(CAP_LSB + 1);
  localparam logic [CNT_W-1:0] C_CAP_END  = CNT_W'(CAP_LSB + NUM_CAP);
  localparam logic [CNT_W-1:0] C_CRC_TOP  = CNT_W'(CRC_W - 1);
  localparam logic [AW-1:0]    F_LAST     = AW'(NUM_FRAMES - 1);
  localparam logic [AW-1:0]    F_CAP      = AW'(CAP_FRAME);

  logic                 trig_q;
  logic                 start;
  logic                 cap_mode_q;
  logic [NUM_CAP-1:0]   cap_q;
  rb_phase_e            phase;
  logic [CNT_W-1:0]     cnt;
  logic [AW-1:0]        frame_idx;
  logic [DATA_BITS-1:0] word_q;
  logic [CRC_W-1:0]     crc;
  logic                 nxt_bit;
  logic [DIW-1:0]       data_idx;
  logic [CIW-1:0]       cap_idx;
  logic [CRIW-1:0]      crc_idx;
  logic                 in_cap;

  assign start = rd_trig & ~trig_q & ~rd_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q     <= 1'b0;
      cap_mode_q <= 1'b0;
      cap_q      <= '0;
    end else begin
      trig_q <= rd_trig;
      if (start) begin
        cap_mode_q <= cap_en;
        cap_q      <= cap_state;
      end
    end
  end

  rb_sequencer #(
    .NUM_FRAMES(NUM_FRAMES),
    .FRAME_LEN (FRAME_LEN),
    .CNT_W     (CNT_W),
    .FW        (AW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .phase    (phase),
    .cnt      (cnt),
    .frame_idx(frame_idx),
    .busy     (rd_busy)
  );

  rb_store #(
    .DEPTH(NUM_FRAMES),
    .WIDTH(DATA_BITS)
  ) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_word),
    .raddr(frame_idx),
    .rdata(word_q)
  );

  rb_crc11 u_crc (
    .clk(clk),
    .rst(rst),
    .clr(start),
    .en (phase == PH_FRAME),
    .din(nxt_bit),
    .crc(crc)
  );

  assign data_idx = DIW'(cnt - CNT_W'(1));
  assign cap_idx  = CIW'(cnt - C_CAP_BEG);
  assign crc_idx  = CRIW'(C_CRC_TOP - cnt);
  assign in_cap   = (frame_idx == F_CAP) && (cnt >= C_CAP_BEG) && (cnt <= C_CAP_END);

  always_comb begin
    nxt_bit = 1'b1;
    unique case (phase)
      PH_FRAME: begin
        if (cnt == '0)                                    nxt_bit = 1'b0;
        else if (cnt > C_DATA_END)                        nxt_bit = 1'b1;
        else if (frame_idx == '0 && cnt <= C_HEAD_END)    nxt_bit = 1'b1;
        else if (frame_idx == F_LAST && cnt >= C_TAIL_BEG) nxt_bit = 1'b1;
        else if (in_cap && cap_mode_q)                    nxt_bit = ~cap_q[cap_idx];
        else                                              nxt_bit = word_q[data_idx];
      end
      PH_TAIL: nxt_bit = 1'b0;
      PH_CRC:  nxt_bit = crc[crc_idx];
      default: nxt_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 1'b1;
    else     rd_data <= nxt_bit;
  end
endmodule

// File: rtl/cfg_readback_serializer_chk.sv
module cfg_readback_serializer_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int DATA_BITS  = 12
) (
  input logic clk,
  input logic rst,
  input logic rd_trig,
  input logic rd_busy,
  input logic rd_data
);
  localparam int RUN_LEN = 5 + NUM_FRAMES * (DATA_BITS + 5) + 1 + 11 + 1;

  int unsigned busy_cycles;

  always_ff @(posedge clk) begin
    if (rst || !rd_busy) busy_cycles <= 0;
    else                 busy_cycles <= busy_cycles + 1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!rd_busy && rd_data)); // R1
  AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_trig) && !rd_busy) |=> rd_busy); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !rd_busy |-> rd_data); // R2
  AST_FIRST_DUMMY: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_busy) |=> rd_data); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_busy) && !$past(rst)) |-> (busy_cycles == RUN_LEN)); // R11
endmodule

bind cfg_readback_serializer cfg_readback_serializer_chk #(
  .NUM_FRAMES(NUM_FRAMES),
  .DATA_BITS (DATA_BITS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rd_trig(rd_trig),
  .rd_busy(rd_busy),
  .rd_data(rd_data)
);

// File: tb/cfg_readback_serializer_tb.sv
`timescale 1ns/1ps
module cfg_readback_serializer_tb;
  localparam int NF = 4;
  localparam int DB = 12;
  localparam int NC = 4;
  localparam int CF = 1;
  localparam int CL = 4;
  localparam int AW = 2;
  localparam int FL = DB + 5;
  localparam int L  = 5 + NF * FL + 1 + 11;
  localparam logic [10:0] POLY = 11'h385;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_trig = 1'b0;
  logic cap_en = 1'b0;
  logic [NC-1:0] cap_state = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DB-1:0] wr_word = '0;
  logic rd_busy, rd_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [DB-1:0] model [NF];
  logic exp_bit [L];
  string exp_tag [L];

  always #2.5 clk = ~clk;

  cfg_readback_serializer #(
    .NUM_FRAMES(NF), .DATA_BITS(DB), .NUM_CAP(NC), .CAP_FRAME(CF), .CAP_LSB(CL)
  ) u_dut (
    .clk(clk), .rst(rst), .rd_trig(rd_trig), .cap_en(cap_en), .cap_state(cap_state),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .rd_busy(rd_busy), .rd_data(rd_data)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [DB-1:0] w);
    wr_en = 1'b1; wr_addr = AW'(a); wr_word = w;
    step();
    wr_en = 1'b0;
    model[a] = w;
  endtask

  task automatic build(input bit cap, input logic [NC-1:0] st);
    int p;
    logic b;
    logic fb;
    logic [10:0] c;
    string t;
    p = 0; c = '0;
    for (int i = 0; i < 5; i++) begin exp_bit[p] = 1'b1; exp_tag[p] = "R3 dummy"; p++; end
    for (int f = 0; f < NF; f++) begin
      for (int j = 0; j < FL; j++) begin
        int d;
        d = j - 1;
        if (j == 0)                              begin b = 1'b0; t = "R3 start"; end
        else if (j > DB)                         begin b = 1'b1; t = "R6 check"; end
        else if (f == 0 && d < 2)                begin b = 1'b1; t = "R5 head"; end
        else if (f == NF - 1 && j >= FL - 7)     begin b = 1'b1; t = "R7 tail"; end
        else if (f == CF && d >= CL && d < CL + NC) begin
          if (cap) begin b = ~st[d - CL]; t = "R9 capture"; end
          else     begin b = model[f][d]; t = "R10 nocapture"; end
        end
        else                                     begin b = model[f][d]; t = "R4 data"; end
        exp_bit[p] = b; exp_tag[p] = t; p++;
        fb = c[10] ^ b;
        c = {c[9:0], 1'b0} ^ (fb ? POLY : 11'h0);
      end
    end
    exp_bit[p] = 1'b0; exp_tag[p] = "R8 final start"; p++;
    for (int k = 10; k >= 0; k--) begin exp_bit[p] = c[k]; exp_tag[p] = "R8 crc"; p++; end
  endtask

  // mode: 0 plain, 1 poke trigger mid-run, 2 hold trigger high, 3 reset at bit 30
  task automatic run_rb(input bit cap, input logic [NC-1:0] st, input int mode);
    build(cap, st);
    rd_trig = 1'b1; cap_en = cap; cap_state = st;
    step();
    check(rd_busy, 1'b1, "R2", "busy after trigger edge");
    check(rd_data, 1'b1, "R2", "line high in first busy cycle");
    if (mode != 2) rd_trig = 1'b0;
    cap_state = ~st;
    cap_en = ~cap;
    for (int i = 0; i < L; i++) begin
      if (mode == 1 && i == 20) rd_trig = 1'b1;
      if (mode == 1 && i == 23) rd_trig = 1'b0;
      if (mode == 3 && i == 30) begin
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(rd_busy, 1'b0, "R1", "busy after mid-run reset");
        check(rd_data, 1'b1, "R1", "data after mid-run reset");
        step();
        check(rd_busy, 1'b0, "R1", "stays idle after reset");
        return;
      end
      step();
      check(rd_data, exp_bit[i], exp_tag[i], $sformatf("bit %0d", i));
      check(rd_busy, 1'b1, "R8", $sformatf("busy at bit %0d", i));
    end
    step();
    check(rd_busy, 1'b0, "R8", "busy falls after crc");
    check(rd_data, 1'b1, "R8", "line idles high after crc");
    for (int i = 0; i < 3; i++) begin
      step();
      check(rd_busy, 1'b0, (mode == 2) ? "R2" : "R11", "no further readback");
      check(rd_data, 1'b1, "R11", "idle line");
    end
    rd_trig = 1'b0;
    step();
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    check(rd_busy, 1'b0, "R1", "busy in reset");
    check(rd_data, 1'b1, "R1", "data in reset");
    rst = 1'b0;
    step();
    check(rd_busy, 1'b0, "R1", "busy after reset");

    for (int f = 0; f < NF; f++) write_word(f, '0);
    run_rb(1'b0, 4'h0, 0);                       // R6 R7 R5 forced highs vs zeros
    for (int f = 0; f < NF; f++) write_word(f, '1);
    run_rb(1'b0, 4'h0, 0);                       // R3 R8 low starts vs ones
    run_rb(1'b1, 4'hF, 0);                       // R9 inverted capture in ones
    for (int f = 0; f < NF; f++) write_word(f, (f % 2) ? 12'hAAA : 12'h555);
    run_rb(1'b1, 4'h5, 1);                       // R9 R11 poke during busy
    for (int f = 0; f < NF; f++) write_word(f, DB'((f + 1) * 12'h1C7 ^ (f << 5)));
    run_rb(1'b0, 4'hA, 2);                       // R10 R4 R2 held trigger
    run_rb(1'b1, 4'h3, 3);                       // R1 reset mid run
    run_rb(1'b1, 4'hC, 0);                       // R1 clean run after abort
    for (int r = 0; r < 6; r++) begin
      for (int f = 0; f < NF; f++) write_word(f, DB'($urandom));
      run_rb(r[0], NC'($urandom), 0);            // R4 R8 R9 R10 random
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule